// File: doc/BRIEF.md
# Multiplexed Dot-Matrix Refresh Scanner

This block drives the time-multiplexed refresh of a row of 5×7 dot-matrix character cells. It walks a one-hot row select through seven rows, holding each row for a fixed number of scan ticks. For the active row it produces five column bits per digit. The column bits come from a glyph lookup that sits outside the block. The block presents each digit's stored character code and a row index, and the lookup answers with five bits per digit.

A cursor-enable input swaps the glyph for a solid block at every digit whose cursor bit is set. This block is shown at half brightness by lighting it on alternate scan ticks only. The cursor path stays under the same per-digit enable that an external blanking/dimming stage supplies. A digit reported as disabled shows no dots. The lookup always asks for the row that comes next, and the answer is captured on the tick that changes the row. Row select and column data therefore move on the same clock edge. The first tick of every row drives all columns dark to stop ghosting.

Top module: `matrix_refresh_scanner`

## Requirements
- R1: Out of reset, row_sel_o selects the last row (bit 6 only, 7'h40) and every column output is 0.
- R2: Each tick_i pulse is one scan tick. A row is held for ROW_TICKS ticks and then the scan moves to the next row, cycling 0,1,…,6,0. row_sel_o is one-hot with bit n set for row n. The first tick after reset enters row 0.
- R3: While tick_i is low, row_sel_o and col_o do not change.
- R4: On the first tick of every row, all column outputs are 0.
- R5: On the other ticks of a row, digit d's columns equal the lookup result for digit d's code and that row. The code is the one present on the row's first tick, and later code changes inside the row have no effect. glyph_row_o always carries the row that follows the displayed one.
- R6: A digit whose digit_on_i bit was 0 at a tick shows all-zero columns after that tick, cursor or not.
- R7: With cursor_en_i=1 and cursor bit d=1 (and digit on, not the boundary tick), digit d shows all five columns on after odd-numbered ticks (the 1st, 3rd, … since reset) and all off after even-numbered ticks.
- R8: With cursor_en_i=0, every digit shows its glyph whatever the cursor bits hold.
- R9: Digit 0, the rightmost position, uses col_o[4:0], and digit d uses col_o[5d+4:5d]. Digit d's code is char_code_i[7d+6:7d] and its lookup result is glyph_bits_i[5d+4:5d].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle scan tick strobe |
| char_code_i | input | 28 | Stored character codes, 7 bits per digit |
| cursor_bits_i | input | 4 | Stored per-digit cursor bits |
| cursor_en_i | input | 1 | Show cursor instead of glyph where cursor bit is set |
| digit_on_i | input | 4 | Per-digit enable from the blanking/dimming stage |
| glyph_code_o | output | 28 | Character codes presented to the glyph lookup |
| glyph_row_o | output | 3 | Row index presented to the glyph lookup (next row) |
| glyph_bits_i | input | 20 | Lookup result, 5 column bits per digit |
| row_sel_o | output | 7 | One-hot row select |
| col_o | output | 20 | Column drive, 5 bits per digit |

## Verification
The bench builds the block with ROW_TICKS=3 instead of the default 4. The full seven-row cycle then wraps several times within about a hundred ticks, so the row-6-to-row-0 wrap, the dark boundary tick and the mid-row code change are each seen many times. With an odd dwell, the cursor's on/off phase falls on a different tick of each row. This exercises the half-brightness alternation separately from the row counter.

// File: rtl/mscan_pkg.sv
package mscan_pkg;
  // next-state flags the timer hands to the column stage
  typedef struct packed {
    logic row_load;   // this tick starts a new row
    logic blank;      // columns dark after this tick
    logic phase;      // cursor phase after this tick
  } scan_flags_t;
endpackage

// File: rtl/mscan_timer.sv
module mscan_timer #(
  parameter int NUM_ROWS  = 7,
  parameter int ROW_TICKS = 4,
  localparam int ROW_W    = $clog2(NUM_ROWS),
  localparam int CNT_W    = $clog2(ROW_TICKS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tick_i,
  output logic [ROW_W-1:0]      row_next_o,
  output logic [NUM_ROWS-1:0]   row_sel_o,
  output mscan_pkg::scan_flags_t flags_o
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ROW_TICKS - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(NUM_ROWS - 1);

  logic [CNT_W-1:0]    cnt_q;
  logic [ROW_W-1:0]    row_q;
  logic [NUM_ROWS-1:0] sel_q;
  logic                phase_q;
  logic                at_end;

  assign at_end     = (cnt_q == CNT_LAST);
  assign row_next_o = (row_q == ROW_LAST) ? '0 : row_q + 1'b1;

  assign flags_o.row_load = at_end;
  assign flags_o.blank    = at_end;
  assign flags_o.phase    = ~phase_q;
  assign row_sel_o        = sel_q;

  // reset parks on the last tick of the last row so the first tick loads row 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= CNT_LAST;
      row_q   <= ROW_LAST;
      sel_q   <= NUM_ROWS'(1) << (NUM_ROWS - 1);
      phase_q <= 1'b0;
    end else if (tick_i) begin
      phase_q <= ~phase_q;
      if (at_end) begin
        cnt_q <= '0;
        row_q <= row_next_o;
        sel_q <= {sel_q[NUM_ROWS-2:0], sel_q[NUM_ROWS-1]};
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mscan_glyph_latch.sv
module mscan_glyph_latch #(
  parameter int NUM_DIGITS = 4,
  parameter int NUM_COLS   = 5,
  localparam int BUS_W     = NUM_DIGITS * NUM_COLS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [BUS_W-1:0] glyph_bits_i,
  output logic [BUS_W-1:0] glyph_o
);
  for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_dig
    logic [NUM_COLS-1:0] bits_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     bits_q <= '0;
      else if (load_i) bits_q <= glyph_bits_i[d*NUM_COLS +: NUM_COLS];
    end
    assign glyph_o[d*NUM_COLS +: NUM_COLS] = bits_q;
  end
endmodule

// File: rtl/mscan_col_gate.sv
module mscan_col_gate #(
  parameter int NUM_DIGITS = 4,
  parameter int NUM_COLS   = 5,
  localparam int BUS_W     = NUM_DIGITS * NUM_COLS
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   tick_i,
  input  mscan_pkg::scan_flags_t flags_i,
  input  logic                   cursor_en_i,
  input  logic [NUM_DIGITS-1:0]  cursor_bits_i,
  input  logic [NUM_DIGITS-1:0]  digit_on_i,
  input  logic [BUS_W-1:0]       glyph_i,
  output logic [BUS_W-1:0]       col_o
);
  for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_dig
    logic [NUM_COLS-1:0] col_q;
    logic [NUM_COLS-1:0] col_d;
    logic                show_cur;

    assign show_cur = cursor_en_i & cursor_bits_i[d];

    always_comb begin
      if (flags_i.blank || !digit_on_i[d]) col_d = '0;
      else if (show_cur)                   col_d = {NUM_COLS{flags_i.phase}};
      else                                 col_d = glyph_i[d*NUM_COLS +: NUM_COLS];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     col_q <= '0;
      else if (tick_i) col_q <= col_d;
    end
    assign col_o[d*NUM_COLS +: NUM_COLS] = col_q;
  end
endmodule

// File: rtl/matrix_refresh_scanner.sv
module matrix_refresh_scanner #(
  parameter int NUM_DIGITS = 4,
  parameter int NUM_ROWS   = 7,
  parameter int NUM_COLS   = 5,
  parameter int CODE_W     = 7,
  parameter int ROW_TICKS  = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           tick_i,
  input  logic [NUM_DIGITS*CODE_W-1:0]   char_code_i,
  input  logic [NUM_DIGITS-1:0]          cursor_bits_i,
  input  logic                           cursor_en_i,
  input  logic [NUM_DIGITS-1:0]          digit_on_i,
  output logic [NUM_DIGITS*CODE_W-1:0]   glyph_code_o,
  output logic [$clog2(NUM_ROWS)-1:0]    glyph_row_o,
  input  logic [NUM_DIGITS*NUM_COLS-1:0] glyph_bits_i,
  output logic [NUM_ROWS-1:0]            row_sel_o,
  output logic [NUM_DIGITS*NUM_COLS-1:0] col_o
);
  localparam int BUS_W = NUM_DIGITS * NUM_COLS;

  mscan_pkg::scan_flags_t flags;
  logic [BUS_W-1:0]       glyph_q;

  assign glyph_code_o = char_code_i;

  mscan_timer #(
    .NUM_ROWS (NUM_ROWS),
    .ROW_TICKS(ROW_TICKS)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .row_next_o(glyph_row_o),
    .row_sel_o (row_sel_o),
    .flags_o   (flags)
  );

  mscan_glyph_latch #(
    .NUM_DIGITS(NUM_DIGITS),
    .NUM_COLS  (NUM_COLS)
  ) u_latch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (tick_i & flags.row_load),
    .glyph_bits_i(glyph_bits_i),
    .glyph_o     (glyph_q)
  );

  mscan_col_gate #(
    .NUM_DIGITS(NUM_DIGITS),
    .NUM_COLS  (NUM_COLS)
  ) u_gate (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .flags_i      (flags),
    .cursor_en_i  (cursor_en_i),
    .cursor_bits_i(cursor_bits_i),
    .digit_on_i   (digit_on_i),
    .glyph_i      (glyph_q),
    .col_o        (col_o)
  );
endmodule

// File: rtl/mscan_checker.sv
module mscan_checker #(
  parameter int NUM_DIGITS = 4,
  parameter int NUM_ROWS   = 7,
  parameter int NUM_COLS   = 5
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           tick_i,
  input logic                           cursor_en_i,
  input logic [NUM_DIGITS-1:0]          cursor_bits_i,
  input logic [NUM_DIGITS-1:0]          digit_on_i,
  input logic [NUM_ROWS-1:0]            row_sel_o,
  input logic [NUM_DIGITS*NUM_COLS-1:0] col_o
);
  p_row_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(row_sel_o) == 1);

  p_hold_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(row_sel_o) && $stable(col_o)));

  p_dark_boundary_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> ($stable(row_sel_o) || (col_o == '0)));

  for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_dig
    p_digit_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && !digit_on_i[d]) |=> (col_o[d*NUM_COLS +: NUM_COLS] == '0));

    p_cursor_solid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && cursor_en_i && cursor_bits_i[d]) |=>
        ((col_o[d*NUM_COLS +: NUM_COLS] == '0) ||
         (col_o[d*NUM_COLS +: NUM_COLS] == {NUM_COLS{1'b1}})));
  end
endmodule

bind matrix_refresh_scanner mscan_checker #(
  .NUM_DIGITS(NUM_DIGITS),
  .NUM_ROWS  (NUM_ROWS),
  .NUM_COLS  (NUM_COLS)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tick_i       (tick_i),
  .cursor_en_i  (cursor_en_i),
  .cursor_bits_i(cursor_bits_i),
  .digit_on_i   (digit_on_i),
  .row_sel_o    (row_sel_o),
  .col_o        (col_o)
);

// File: tb/matrix_refresh_scanner_bench.sv
module matrix_refresh_scanner_bench;
  localparam int ND = 4, NR = 7, NC = 5, CW = 7, RT = 3;

  typedef struct {
    logic [NR-1:0]    rs;
    logic [ND*NC-1:0] col;
    logic [2:0]       grow;
    string            tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic [ND*CW-1:0] codes = '0;
  logic [ND-1:0]    cbits = '0, don = '1;
  logic             cen = 1'b0;
  logic [ND*CW-1:0] gcode;
  logic [2:0]       grow;
  logic [ND*NC-1:0] gbits, col;
  logic [NR-1:0]    rsel;

  int checks = 0, fails = 0, k = 0;
  logic [CW-1:0] lat [ND];
  exp_t q[$];
  exp_t last;
  event sample_ev;
  bit done = 0;

  always #10 clk = ~clk;

  function automatic logic [NC-1:0] font(logic [CW-1:0] c, int r);
    return NC'((int'(c) * 3 + r * 5) ^ (int'(c) >> 2));
  endfunction

  always_comb
    for (int d = 0; d < ND; d++)
      gbits[d*NC +: NC] = font(gcode[d*CW +: CW], int'(grow));

  matrix_refresh_scanner #(.NUM_DIGITS(ND), .NUM_ROWS(NR), .NUM_COLS(NC),
                           .CODE_W(CW), .ROW_TICKS(RT)) u_matrix_refresh_scanner (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .char_code_i(codes),
    .cursor_bits_i(cbits), .cursor_en_i(cen), .digit_on_i(don),
    .glyph_code_o(gcode), .glyph_row_o(grow), .glyph_bits_i(gbits),
    .row_sel_o(rsel), .col_o(col));

  task automatic check(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  // driver: one scan tick, expected item from the requirements
  task automatic do_tick(input string tag);
    exp_t e;
    int p, row, cnt;
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    k++;
    p = k - 1; row = (p / RT) % NR; cnt = p % RT;
    if (cnt == 0) for (int d = 0; d < ND; d++) lat[d] = codes[d*CW +: CW];
    e.rs = NR'(1) << row;
    e.grow = 3'((row + 1) % NR);
    e.tag = tag;
    for (int d = 0; d < ND; d++) begin
      logic [NC-1:0] v;
      if (cnt == 0 || !don[d]) v = '0;
      else if (cen && cbits[d]) v = (k % 2 == 1) ? '1 : '0;
      else v = font(lat[d], row);
      e.col[d*NC +: NC] = v;
    end
    q.push_back(e);
    last = e;
    -> sample_ev;
  endtask

  task automatic idle(input int n);
    exp_t e;
    repeat (n) @(negedge clk);
    e = last; e.tag = "R3 idle hold";
    q.push_back(e);
    -> sample_ev;
  endtask

  // monitor
  initial forever begin
    exp_t e;
    @(sample_ev);
    while (q.size() > 0) begin
      e = q.pop_front();
      check(rsel == e.rs && col == e.col && grow == e.grow, e.tag,
            $sformatf("row_sel=%h col=%h grow=%0d exp row_sel=%h col=%h grow=%0d",
                      rsel, col, grow, e.rs, e.col, e.grow));
    end
  end

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog: run hung");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    codes = {7'h41, 7'h35, 7'h7A, 7'h12};
    repeat (3) @(negedge clk);
    check(rsel == 7'h40 && col == '0, "R1",
          $sformatf("reset row_sel=%h col=%h exp 40/0", rsel, col));
    rst_n = 1'b1;
    @(negedge clk);
    // R2 R4 R5: plain scan through several wraps
    for (int i = 0; i < 30; i++) do_tick("R2 R4 R5 scan");
    // R5: code change mid-row is not seen until next row
    do_tick("R5 row start");
    while (((k - 1) % RT) == 0) do_tick("R5 align");
    codes = {7'h03, 7'h66, 7'h29, 7'h5C};
    for (int i = 0; i < 8; i++) do_tick("R5 mid-row code change");
    // R3
    idle(6);
    // R6 / R9
    don = 4'b0101;
    for (int i = 0; i < 8; i++) do_tick("R6 digit gate");
    don = 4'b0001;
    for (int i = 0; i < 6; i++) do_tick("R9 digit0 rightmost slice");
    // R7 cursor half brightness
    don = '1; cen = 1'b1; cbits = 4'b1010;
    for (int i = 0; i < 12; i++) do_tick("R7 cursor");
    idle(3);
    // R8 cursor bits ignored when disabled
    cen = 1'b0; cbits = 4'b1111;
    for (int i = 0; i < 8; i++) do_tick("R8 cursor off");
    // R6 with cursor
    cen = 1'b1; don = 4'b0110;
    for (int i = 0; i < 8; i++) do_tick("R6 R7 cursor gated");
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule